// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple 32-bit processor and decides, one instruction at a time, where execution goes next. Each accepted instruction word is decoded together with two register operands that arrive from outside (the values read for the `rs` and `rt` fields). The unit covers plain sequential advance, two conditional branches (equality and "signed value not negative"), absolute jumps inside the current 256 MiB region, and jumps through a register. The call forms of the two jumps also ask for a register write that stores the return address.

Instructions reach the block as a stream with `in_valid` as the only qualifier. The unit has no ready signal and never applies back-pressure, because the next program counter is always known within the cycle. A beat is consumed on every rising clock edge where `in_valid` is high. When `in_valid` is low the counter holds and no link request is made. The link request is an output stream with no ready. It is meaningful only in the cycle its instruction is presented, and the register file must take it in that cycle.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low the program counter is 0 at every rising edge, and it is 0 on the first cycle after release.
- R2: In a cycle with `in_valid` low the program counter does not change at the next edge and `lnk_valid` is low.
- R3: An instruction that is not a branch or jump advances the counter by 4. This includes opcode 0 with a function code other than 8 or 9, and opcode 1 whose bits [20:16] are not 1.
- R4: Opcode 4 (bits [31:26]) compares `rs_val` with `rt_val`. When they are equal the counter becomes PC + 4 + 4 × sign-extended bits [15:0]. Otherwise it becomes PC + 4.
- R5: Opcode 1 with bits [20:16] equal to 1 branches to the same relative target when `rs_val` is 0 or positive as a signed number. When `rs_val` is negative the counter becomes PC + 4.
- R6: Opcode 2 sets the counter to bits [31:28] of PC + 4, followed by bits [25:0] of the instruction, followed by two zero bits. It makes no link request.
- R7: Opcode 3 jumps to the same target as R6 and asserts `lnk_valid` in the same cycle, with `lnk_idx` = 31 and `lnk_data` = PC + 8.
- R8: Opcode 0 with function code (bits [5:0]) 8 sets the counter to `rs_val` and makes no link request.
- R9: Opcode 0 with function code 9 sets the counter to `rs_val` and requests a link write of PC + 8 into the register named by bits [15:11].
- R10: A link request whose destination index is 0 is suppressed, so `lnk_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction beat present this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Register value selected by bits [25:21] |
| rt_val | input | 32 | Register value selected by bits [20:16] |
| pc | output | 32 | Current program counter |
| lnk_valid | output | 1 | Link write requested this cycle |
| lnk_idx | output | 5 | Destination register of the link write |
| lnk_data | output | 32 | Return address, PC + 8 |

## Verification
The assertions assume that `instr`, `rs_val` and `rt_val` carry known values whenever `in_valid` is high. They do not assume alignment of `rs_val`, because a register jump may legally land on any address. The random stimulus weights the opcode choice toward the six control-flow encodings and also covers neighbouring function codes and `rt` field values. It makes the two operands equal about half the time so that both outcomes of the equality branch occur, and it drops `in_valid` on a fraction of cycles so that the hold behaviour is exercised between real beats.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;

  localparam logic [OPC_W-1:0]   OPC_REGOP  = 6'h00;
  localparam logic [OPC_W-1:0]   OPC_SIGNBR = 6'h01;
  localparam logic [OPC_W-1:0]   OPC_JUMP   = 6'h02;
  localparam logic [OPC_W-1:0]   OPC_CALL   = 6'h03;
  localparam logic [OPC_W-1:0]   OPC_EQBR   = 6'h04;
  localparam logic [FUNCT_W-1:0] FN_JREG    = 6'h08;
  localparam logic [FUNCT_W-1:0] FN_JREGLNK = 6'h09;
  localparam logic [RIDX_W-1:0]  RT_GEZ     = 5'd1;
  localparam logic [RIDX_W-1:0]  RA_IDX     = 5'd31;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_EQ,
    FLOW_GEZ,
    FLOW_ABS,
    FLOW_REG
  } flow_e;

  typedef struct packed {
    flow_e             flow;
    logic              link_req;
    logic [RIDX_W-1:0] link_dst;
    logic [IMM_W-1:0]  offset;
    logic [JIDX_W-1:0] region_idx;
  } ctl_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output ctl_t            ctl
);
  logic [OPC_W-1:0]   opc;
  logic [FUNCT_W-1:0] fn;
  logic [RIDX_W-1:0]  rt_f;
  logic [RIDX_W-1:0]  rd_f;

  assign opc  = instr[31:26];
  assign fn   = instr[5:0];
  assign rt_f = instr[20:16];
  assign rd_f = instr[15:11];

  always_comb begin
    ctl            = '0;
    ctl.flow       = FLOW_SEQ;
    ctl.offset     = instr[IMM_W-1:0];
    ctl.region_idx = instr[JIDX_W-1:0];
    unique case (opc)
      OPC_REGOP: begin
        if (fn == FN_JREG) begin
          ctl.flow = FLOW_REG;
        end else if (fn == FN_JREGLNK) begin
          ctl.flow     = FLOW_REG;
          ctl.link_req = 1'b1;
          ctl.link_dst = rd_f;
        end
      end
      OPC_SIGNBR: if (rt_f == RT_GEZ) ctl.flow = FLOW_GEZ;
      OPC_JUMP:   ctl.flow = FLOW_ABS;
      OPC_CALL: begin
        ctl.flow     = FLOW_ABS;
        ctl.link_req = 1'b1;
        ctl.link_dst = RA_IDX;
      end
      OPC_EQBR:   ctl.flow = FLOW_EQ;
      default:    ctl.flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e           flow,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            taken
);
  logic eq_hit;
  logic gez_hit;

  assign eq_hit  = (opa == opb);
  assign gez_hit = ~opa[XLEN-1];

  always_comb begin
    unique case (flow)
      FLOW_EQ:  taken = eq_hit;
      FLOW_GEZ: taken = gez_hit;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_cur,
  input  ctl_t            ctl,
  input  logic            taken,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] ret_addr
);
  localparam int EXT_W    = XLEN - IMM_W - 2;
  localparam int REGION_W = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_off;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] abs_pc;

  assign seq_pc   = pc_cur + XLEN'(4);
  assign ret_addr = pc_cur + XLEN'(8);
  assign rel_off  = {{EXT_W{ctl.offset[IMM_W-1]}}, ctl.offset, 2'b00};
  assign rel_pc   = seq_pc + rel_off;
  assign abs_pc   = {seq_pc[XLEN-1 -: REGION_W], ctl.region_idx, 2'b00};

  always_comb begin
    unique case (ctl.flow)
      FLOW_EQ, FLOW_GEZ: pc_next = taken ? rel_pc : seq_pc;
      FLOW_ABS:          pc_next = abs_pc;
      FLOW_REG:          pc_next = reg_tgt;
      default:           pc_next = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic [XLEN-1:0]   pc,
  output logic              lnk_valid,
  output logic [RIDX_W-1:0] lnk_idx,
  output logic [XLEN-1:0]   lnk_data
);
  ctl_t            ctl;
  logic            taken;
  logic [XLEN-1:0] pc_nx;
  logic [XLEN-1:0] ret_addr;

  npc_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr),
    .ctl   (ctl)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .flow  (ctl.flow),
    .opa   (rs_val),
    .opb   (rt_val),
    .taken (taken)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc_cur   (pc),
    .ctl      (ctl),
    .taken    (taken),
    .reg_tgt  (rs_val),
    .pc_next  (pc_nx),
    .ret_addr (ret_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        pc <= '0;
    else if (in_valid) pc <= pc_nx;
  end

  assign lnk_valid = in_valid & ctl.link_req & (ctl.link_dst != '0);
  assign lnk_idx   = ctl.link_dst;
  assign lnk_data  = ret_addr;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [XLEN-1:0]   instr,
  input logic [XLEN-1:0]   rs_val,
  input logic [XLEN-1:0]   pc,
  input logic              lnk_valid,
  input logic [RIDX_W-1:0] lnk_idx,
  input logic [XLEN-1:0]   lnk_data
);
  logic plain_reg_op;
  logic is_jreg;
  assign plain_reg_op = (instr[31:26] == OPC_REGOP) && (instr[5:0] != FN_JREG) && (instr[5:0] != FN_JREGLNK);
  assign is_jreg      = (instr[31:26] == OPC_REGOP) && (instr[5:0] == FN_JREG);

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> pc == '0); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(pc)); // R2
  AST_LINK_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n) lnk_valid |-> in_valid); // R2
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n) in_valid && plain_reg_op |=> pc == $past(pc) + XLEN'(4)); // R3
  AST_JREG_TARGET: assert property (@(posedge clk) disable iff (!rst_n) in_valid && is_jreg |=> pc == $past(rs_val)); // R8
  AST_JREG_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n) in_valid && is_jreg |-> !lnk_valid); // R8
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n) lnk_valid |-> lnk_data == pc + XLEN'(8)); // R7
  AST_NO_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n) lnk_valid |-> lnk_idx != '0); // R10
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .rs_val    (rs_val),
  .pc        (pc),
  .lnk_valid (lnk_valid),
  .lnk_idx   (lnk_idx),
  .lnk_data  (lnk_data)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc;
  logic        lnk_valid;
  logic [4:0]  lnk_idx;
  logic [31:0] lnk_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .lnk_valid(lnk_valid),
    .lnk_idx(lnk_idx), .lnk_data(lnk_data)
  );

  function automatic string tag_of(input logic [31:0] w);
    case (w[31:26])
      6'd0: return (w[5:0] == 6'd8) ? "R8" : (w[5:0] == 6'd9) ? "R9" : "R3";
      6'd1: return (w[20:16] == 5'd1) ? "R5" : "R3";
      6'd2: return "R6";
      6'd3: return "R7";
      6'd4: return "R4";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] w,
                                             input logic [31:0] a, input logic [31:0] b);
    logic [31:0] rel;
    rel = p + 32'd4 + ({{16{w[15]}}, w[15:0]} * 32'd4);
    case (w[31:26])
      6'd0: return (w[5:0] == 6'd8 || w[5:0] == 6'd9) ? a : p + 32'd4;
      6'd1: return (w[20:16] == 5'd1 && $signed(a) >= 0) ? rel : p + 32'd4;
      6'd2, 6'd3: return {p[31:28] + 4'(((p & 32'h0FFF_FFFF) + 32'd4) >> 28), w[25:0], 2'b00};
      6'd4: return (a == b) ? rel : p + 32'd4;
      default: return p + 32'd4;
    endcase
  endfunction

  function automatic logic [5:0] model_link(input logic [31:0] w);
    if (w[31:26] == 6'd3) return {1'b1, 5'd31};
    if (w[31:26] == 6'd0 && w[5:0] == 6'd9 && w[15:11] != 5'd0) return {1'b1, w[15:11]};
    return 6'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic [5:0] lk;
    string t;
    @(negedge clk);
    check(v ? tag_of(w) : "R2", pc, exp_pc);
    in_valid = v; instr = w; rs_val = a; rt_val = b;
    #1;
    lk = v ? model_link(w) : 6'd0;
    t = !v ? "R2" : (w[31:26] == 6'd0 && w[5:0] == 6'd9 && w[15:11] == 5'd0) ? "R10" : tag_of(w);
    check(t, {31'd0, lnk_valid}, {31'd0, lk[5]});
    if (lk[5]) begin
      check(t, {27'd0, lnk_idx}, {27'd0, lk[4:0]});
      check(t, lnk_data, exp_pc + 32'd8);
    end
    if (v) exp_pc = model_next(exp_pc, w, a, b);
  endtask

  function automatic logic [31:0] rand_instr();
    logic [31:0] w;
    int sel;
    w = $urandom;
    sel = $urandom_range(0, 9);
    case (sel)
      0, 1: begin w[31:26] = 6'd0; w[5:0] = ($urandom_range(0, 2) == 0) ? 6'd8 : ($urandom_range(0, 1) == 0) ? 6'd9 : 6'($urandom_range(0, 63)); end
      2, 3: begin w[31:26] = 6'd1; if ($urandom_range(0, 3) != 0) w[20:16] = 5'd1; end
      4:    w[31:26] = 6'd2;
      5:    w[31:26] = 6'd3;
      6, 7: w[31:26] = 6'd4;
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", pc, 32'd0);
    rst_n = 1'b1;
    // R3 plain ALU op and unknown function code
    step(1, 32'h0000_0020, 32'd5, 32'd6);
    step(1, 32'h0000_000A, 32'd5, 32'd6);
    // R4 equal forward, equal backward, unequal
    step(1, {6'd4, 5'd1, 5'd2, 16'h0010}, 32'd7, 32'd7);
    step(1, {6'd4, 5'd1, 5'd2, 16'hFFFE}, 32'd7, 32'd7);
    step(1, {6'd4, 5'd1, 5'd2, 16'h0100}, 32'd7, 32'd8);
    // R5 zero, negative, wrong rt field
    step(1, {6'd1, 5'd3, 5'd1, 16'h0004}, 32'd0, 32'd0);
    step(1, {6'd1, 5'd3, 5'd1, 16'h0004}, 32'h8000_0000, 32'd0);
    step(1, {6'd1, 5'd3, 5'd0, 16'h0004}, 32'd9, 32'd0);
    // R8 register jump into a top-region address
    step(1, 32'h0120_0008, 32'hEFFF_FFFC, 32'd0);
    // R6 region keeps PC+4 top bits (carry into new region)
    step(1, {6'd2, 26'h3FF_FFFF}, 32'd0, 32'd0);
    step(1, {6'd2, 26'h000_1234}, 32'd0, 32'd0);
    // R7 call
    step(1, {6'd3, 26'h000_0040}, 32'd0, 32'd0);
    // R9 register call to rd 5, R10 rd 0
    step(1, {6'd0, 5'd4, 5'd0, 5'd5, 5'd0, 6'd9}, 32'h0000_2000, 32'd0);
    step(1, {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'd9}, 32'h0000_3000, 32'd0);
    // R2 idle with a call on the bus
    step(0, {6'd3, 26'h000_0999}, 32'd0, 32'd0);
    step(0, 32'h0000_0009, 32'h1234_5678, 32'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = $urandom;
      step($urandom_range(0, 6) != 0, rand_instr(), a, ($urandom_range(0, 1) == 0) ? a : $urandom);
    end
    @(negedge clk);
    check("R3", pc, exp_pc);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule